// File: doc/BRIEF.md
# Polarity-Aware Synchronous PWM Leg Generator

This block drives the four gates of a bridgeless boost rectifier: a fast half-bridge pair (A and B) that switches at the carrier rate, and a slow pair that follows the mains polarity. A symmetric triangle carrier counts from zero up to a programmable top and back down. The duty command is turned into a compare threshold, and the compare events set or clear the fast pair. Which fast switch is the main (boost) switch and which is the synchronous rectifier depends on the line polarity. Both roles and the compare actions swap when the polarity input changes. The swap, the new threshold and the new top all take effect only at the carrier valley.

At the valley the block also raises a one-cycle converter-start strobe, so the current is sampled in the middle of the main switch's on-time. An active-low light-load flag removes the synchronous switch cycle by cycle while the main switch keeps modulating. Once the flag trips, the synchronous switch stays off until the next valley, even if the flag goes high again earlier. A programmable dead time delays every turn-on edge of the fast pair.

Top module: `polar_sync_pwm`

## Requirements
- R1: While `rst_n` is low, all five outputs are low.
- R2: With `period_i` = P (values below 2 are treated as 2), one carrier period lasts 2P clock cycles. `adc_soc_o` is high for exactly one cycle per period, at the valley, so successive strobes are 2P cycles apart. A new P is adopted only at the valley.
- R3: The compare threshold is c = P - floor(duty_i * P / 2^DUTY_W), with duty_i an unsigned fraction of 2^DUTY_W. Before dead time, the main switch is on for 2c cycles per period, centred on the valley, and the synchronous switch is on for the remaining 2(P - c) cycles.
- R4: With `pol_pos_i` = 1 (positive half), B is the main switch and A is the synchronous switch. A compare match while counting up turns A on and B off. A match while counting down turns A off and B on.
- R5: With `pol_pos_i` = 0 (negative half), A is the main switch and B is the synchronous switch. The compare actions are mirrored.
- R6: In the positive half, `lf_a_o` = 0 and `lf_b_o` = 1. In the negative half, `lf_a_o` = 1 and `lf_b_o` = 0.
- R7: A change of `pol_pos_i` is adopted only at the valley. The slow-leg outputs change in the cycle after the strobe and hold at every other time.
- R8: While `dcm_n_i` is low, the synchronous switch's gate is low from the next cycle on. The main switch keeps its normal pattern.
- R9: After `dcm_n_i` has been low, the synchronous switch stays off until the next valley, even if the flag returns high mid-period.
- R10: With `dead_i` = D, each rising edge of a fast gate is delayed by D cycles and each falling edge is not delayed. A pulse of width W therefore gives max(W - D, 0) high cycles. The two fast gates are never high together.
- R11: `en_a_i` = 0 holds `hf_a_o` low, and `en_b_i` = 0 holds `hf_b_o` low. The other fast gate is not affected.
- R12: With duty_i = 0, the main switch is on for the whole period and the synchronous switch never turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_i | input | DUTY_W | Duty command, fraction of 2^DUTY_W |
| period_i | input | CNT_W | Carrier top value P |
| pol_pos_i | input | 1 | Line polarity, 1 = positive half |
| dcm_n_i | input | 1 | Light-load flag, active low |
| en_a_i | input | 1 | Enable for fast switch A |
| en_b_i | input | 1 | Enable for fast switch B |
| dead_i | input | DT_W | Dead time in clock cycles |
| hf_a_o | output | 1 | Gate of fast switch A |
| hf_b_o | output | 1 | Gate of fast switch B |
| lf_a_o | output | 1 | Gate of slow switch A |
| lf_b_o | output | 1 | Gate of slow switch B |
| adc_soc_o | output | 1 | Converter start strobe at the valley |

## Verification
The bench counts high cycles per carrier period in both polarities. A design with the compare actions not mirrored would give the main switch's count to the wrong gate. It targets the duty extremes: duty 0 must leave the main gate on through the valley, and a near-full duty gives a main pulse narrower than the dead time, which must vanish rather than glitch. A top below 2 and a large top check that the strobe spacing tracks the period. The bench releases the light-load flag in mid-period and also flips the polarity in mid-period. A trip latch that opens too early shows up as a partial synchronous pulse, and a polarity adopted before the valley shows up as the slow leg moving outside the cycle after the strobe.

// File: rtl/polar_pwm_pkg.sv
package polar_pwm_pkg;

   // line half selected for the current carrier period
   typedef enum logic {
      HALF_NEG = 1'b0,
      HALF_POS = 1'b1
   } half_e;

   // one gate pair of a leg
   typedef struct packed {
      logic b;
      logic a;
   } leg_t;

   // smallest carrier top that still gives a distinct up and down slope
   localparam int MIN_TOP = 2;

endpackage

// File: rtl/pp_carrier.sv
module pp_carrier
   import polar_pwm_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] top_o,
   output logic             up_o,
   output logic             zero_o,
   output logic             soc_o
);

   localparam logic [CNT_W-1:0] TOP_FLOOR = CNT_W'(MIN_TOP);

   logic [CNT_W-1:0] cnt_q, cnt_d, top_q, top_eff;
   logic             up_q, up_d, soc_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   // the top is only sampled at the valley; elsewhere the held copy rules
   always_comb begin
      if (at_zero) top_eff = (period_i < TOP_FLOOR) ? TOP_FLOOR : period_i;
      else         top_eff = top_q;
   end

   always_comb begin
      cnt_d = cnt_q;
      up_d  = up_q;
      if (up_q) begin
         cnt_d = cnt_q + 1'b1;
         if (cnt_d == top_eff) up_d = 1'b0;
      end else begin
         cnt_d = cnt_q - 1'b1;
         if (cnt_d == '0) up_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
         top_q <= TOP_FLOOR;
         soc_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
         top_q <= top_eff;
         soc_q <= (cnt_d == '0);
      end
   end

   assign cnt_o  = cnt_q;
   assign top_o  = top_eff;
   assign up_o   = up_q;
   assign zero_o = at_zero;
   assign soc_o  = soc_q;

   // R2
   top_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= top_q);

   // R2
   soc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soc_q |=> !soc_q);

endmodule

// File: rtl/pp_qualifier.sv
module pp_qualifier
   import polar_pwm_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int DUTY_W    = 8,
   parameter bit KILL_COMB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  top_i,
   input  logic              up_i,
   input  logic              zero_i,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic              pol_pos_i,
   input  logic              dcm_n_i,
   input  logic              en_a_i,
   input  logic              en_b_i,
   output leg_t              pre_o,
   output leg_t              lf_o,
   output logic              pol_o
);

   localparam int PROD_W = CNT_W + DUTY_W;

   logic [PROD_W-1:0] prod;
   logic [CNT_W-1:0]  cmp_new, cmp_eff, cmp_q;
   half_e             pol_eff, pol_q;
   leg_t              leg_q, leg_d, lf_q;
   logic              trip_q, trip_d, kill;
   logic              up_hit, dn_hit, sync_is_a;

   // threshold is (1 - duty) of the top, floor applied to the duty share
   assign prod    = PROD_W'(duty_i) * PROD_W'(top_i);
   assign cmp_new = top_i - CNT_W'(prod >> DUTY_W);

   // shadow values are adopted in the valley cycle itself
   assign cmp_eff = zero_i ? cmp_new : cmp_q;
   assign pol_eff = zero_i ? half_e'(pol_pos_i) : pol_q;

   assign up_hit    = up_i  && (cnt_i == cmp_eff);
   assign dn_hit    = !up_i && (cnt_i == cmp_eff);
   assign sync_is_a = (pol_eff == HALF_POS);

   always_comb begin
      leg_d = leg_q;
      if (zero_i) begin
         // main switch sits on across the valley
         leg_d.a = !sync_is_a;
         leg_d.b = sync_is_a;
      end
      if (up_hit) begin
         leg_d.a = sync_is_a;
         leg_d.b = !sync_is_a;
      end
      if (dn_hit) begin
         leg_d.a = !sync_is_a;
         leg_d.b = sync_is_a;
      end
   end

   // the trip latch re-evaluates at the valley and otherwise only sets
   assign trip_d = zero_i ? !dcm_n_i : (trip_q || !dcm_n_i);

   if (KILL_COMB) begin : g_fast_kill
      assign kill = trip_q || !dcm_n_i;
   end else begin : g_slow_kill
      assign kill = trip_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         pol_q  <= HALF_POS;
         leg_q  <= '0;
         lf_q   <= '0;
         trip_q <= 1'b0;
      end else begin
         cmp_q  <= cmp_eff;
         pol_q  <= pol_eff;
         leg_q  <= leg_d;
         trip_q <= trip_d;
         if (zero_i) begin
            lf_q.a <= !sync_is_a;
            lf_q.b <= sync_is_a;
         end
      end
   end

   assign pre_o.a = leg_q.a && en_a_i && !(kill && sync_is_a);
   assign pre_o.b = leg_q.b && en_b_i && !(kill && !sync_is_a);
   assign lf_o    = lf_q;
   assign pol_o   = sync_is_a;

   // R7
   lf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_i |=> $stable(lf_q));

   // R9
   trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_q && !zero_i) |=> trip_q);

endmodule

// File: rtl/pp_deadband.sv
module pp_deadband #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_i,
   input  logic [DT_W-1:0] dly_i,
   output logic            out_o
);

   logic [DT_W-1:0] wait_q;
   logic            out_q;

   // a rising request must persist for dly_i extra cycles; falls pass at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
         out_q  <= 1'b0;
      end else if (!in_i) begin
         wait_q <= '0;
         out_q  <= 1'b0;
      end else if (wait_q >= dly_i) begin
         out_q  <= 1'b1;
      end else begin
         wait_q <= wait_q + 1'b1;
      end
   end

   assign out_o = out_q;

   // R10
   fall_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_i |=> !out_q);

endmodule

// File: rtl/polar_sync_pwm.sv
module polar_sync_pwm
   import polar_pwm_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int DUTY_W    = 8,
   parameter int DT_W      = 4,
   parameter bit KILL_COMB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic [CNT_W-1:0]  period_i,
   input  logic              pol_pos_i,
   input  logic              dcm_n_i,
   input  logic              en_a_i,
   input  logic              en_b_i,
   input  logic [DT_W-1:0]   dead_i,
   output logic              hf_a_o,
   output logic              hf_b_o,
   output logic              lf_a_o,
   output logic              lf_b_o,
   output logic              adc_soc_o
);

   if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt
      $error("polar_sync_pwm: CNT_W must lie in 3..16");
   end
   if (DUTY_W < 2 || DUTY_W > 16) begin : g_bad_duty
      $error("polar_sync_pwm: DUTY_W must lie in 2..16");
   end
   if (DT_W < 1 || DT_W > 8) begin : g_bad_dt
      $error("polar_sync_pwm: DT_W must lie in 1..8");
   end

   logic [CNT_W-1:0] cnt, top;
   logic             up, zero, pol_sync_a;
   leg_t             pre, lf;
   logic [1:0]       pre_v, gate_v;

   pp_carrier #(.CNT_W(CNT_W)) u_carrier (
      .clk      (clk),
      .rst_n    (rst_n),
      .period_i (period_i),
      .cnt_o    (cnt),
      .top_o    (top),
      .up_o     (up),
      .zero_o   (zero),
      .soc_o    (adc_soc_o)
   );

   pp_qualifier #(
      .CNT_W     (CNT_W),
      .DUTY_W    (DUTY_W),
      .KILL_COMB (KILL_COMB)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt),
      .top_i     (top),
      .up_i      (up),
      .zero_i    (zero),
      .duty_i    (duty_i),
      .pol_pos_i (pol_pos_i),
      .dcm_n_i   (dcm_n_i),
      .en_a_i    (en_a_i),
      .en_b_i    (en_b_i),
      .pre_o     (pre),
      .lf_o      (lf),
      .pol_o     (pol_sync_a)
   );

   assign pre_v = {pre.b, pre.a};

   for (genvar i = 0; i < 2; i++) begin : g_db
      pp_deadband #(.DT_W(DT_W)) u_db (
         .clk   (clk),
         .rst_n (rst_n),
         .in_i  (pre_v[i]),
         .dly_i (dead_i),
         .out_o (gate_v[i])
      );
   end

   assign hf_a_o = gate_v[0];
   assign hf_b_o = gate_v[1];
   assign lf_a_o = lf.a;
   assign lf_b_o = lf.b;

   // R10
   not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_v[0] && gate_v[1]));

   if (KILL_COMB) begin : g_trip_chk
      // R8
      trip_a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!dcm_n_i && pol_sync_a) |=> !hf_a_o);
      // R8
      trip_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!dcm_n_i && !pol_sync_a) |=> !hf_b_o);
   end

endmodule

// File: tb/polar_sync_pwm_test.sv
module polar_sync_pwm_test;

   localparam int CNT_W  = 10;
   localparam int DUTY_W = 8;
   localparam int DT_W   = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DUTY_W-1:0] duty_i = '0;
   logic [CNT_W-1:0]  period_i = '0;
   logic              pol_pos_i = 1'b1;
   logic              dcm_n_i = 1'b1;
   logic              en_a_i = 1'b1;
   logic              en_b_i = 1'b1;
   logic [DT_W-1:0]   dead_i = '0;
   logic              hf_a_o, hf_b_o, lf_a_o, lf_b_o, adc_soc_o;

   polar_sync_pwm #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DT_W(DT_W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .duty_i    (duty_i),
      .period_i  (period_i),
      .pol_pos_i (pol_pos_i),
      .dcm_n_i   (dcm_n_i),
      .en_a_i    (en_a_i),
      .en_b_i    (en_b_i),
      .dead_i    (dead_i),
      .hf_a_o    (hf_a_o),
      .hf_b_o    (hf_b_o),
      .lf_a_o    (lf_a_o),
      .lf_b_o    (lf_b_o),
      .adc_soc_o (adc_soc_o)
   );

   always #10 clk = ~clk;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   int    acc_a = 0, acc_b = 0, acc_len = 0;
   int    exp_a_q[$], exp_b_q[$], exp_len_q[$];
   string tag_q[$];

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: one scoreboard item per carrier period, closed at each strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (adc_soc_o) begin
            if (tag_q.size() > 0) begin
               string t;
               t = tag_q.pop_front();
               chk({t, " hf_a high cycles"}, acc_a, exp_a_q.pop_front());
               chk({t, " hf_b high cycles"}, acc_b, exp_b_q.pop_front());
               chk({t, " R2 period length"}, acc_len, exp_len_q.pop_front());
            end
            acc_a   = 0;
            acc_b   = 0;
            acc_len = 0;
         end
         acc_a   += int'(hf_a_o);
         acc_b   += int'(hf_b_o);
         acc_len += 1;
      end
   end

   task automatic wait_soc(int n);
      for (int k = 0; k < n; k++) begin
         do @(negedge clk); while (!adc_soc_o);
      end
   endtask

   function automatic int hi_cycles(int width, int full, bit en, int dt);
      if (!en || width == 0) return 0;
      if (width >= full) return full;
      if (width <= dt) return 0;
      return width - dt;
   endfunction

   // driver: apply a setting, let it settle, then queue expected periods
   task automatic run_case(string tag, int duty, int per, bit pos, bit dcm,
                           bit ea, bit eb, int dt, int nwin);
      int pe, c, wm, ws, xa, xb;
      @(negedge clk);
      duty_i    = DUTY_W'(duty);
      period_i  = CNT_W'(per);
      pol_pos_i = pos;
      dcm_n_i   = dcm;
      en_a_i    = ea;
      en_b_i    = eb;
      dead_i    = DT_W'(dt);
      wait_soc(3);
      #1;
      pe = (per < 2) ? 2 : per;
      c  = pe - (duty * pe) / (1 << DUTY_W);
      wm = 2 * c;
      ws = 2 * (pe - c);
      if (pos) begin
         xa = hi_cycles(ws, 2 * pe, ea && dcm, dt);
         xb = hi_cycles(wm, 2 * pe, eb, dt);
      end else begin
         xa = hi_cycles(wm, 2 * pe, ea, dt);
         xb = hi_cycles(ws, 2 * pe, eb && dcm, dt);
      end
      for (int k = 0; k < nwin; k++) begin
         tag_q.push_back(tag);
         exp_a_q.push_back(xa);
         exp_b_q.push_back(xb);
         exp_len_q.push_back(2 * pe);
      end
      wait_soc(nwin);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual still running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int cnt;
      duty_i   = 8'd128;
      period_i = 10'd20;
      dead_i   = 4'd2;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 hf_a in reset", int'(hf_a_o), 0);
      chk("R1 hf_b in reset", int'(hf_b_o), 0);
      chk("R1 lf_a in reset", int'(lf_a_o), 0);
      chk("R1 lf_b in reset", int'(lf_b_o), 0);
      chk("R1 strobe in reset", int'(adc_soc_o), 0);
      rst_n = 1'b1;

      // R4: positive half, B main, A synchronous
      run_case("R4 positive half", 64, 20, 1'b1, 1'b1, 1'b1, 1'b1, 2, 2);
      // R6: slow leg levels in positive half
      chk("R6 lf_a in positive half", int'(lf_a_o), 0);
      chk("R6 lf_b in positive half", int'(lf_b_o), 1);
      // R7: polarity flipped mid-period is held until the valley
      repeat (5) @(negedge clk);
      pol_pos_i = 1'b0;
      @(negedge clk);
      chk("R7 lf_a held mid-period", int'(lf_a_o), 0);
      chk("R7 lf_b held mid-period", int'(lf_b_o), 1);
      wait_soc(1);
      chk("R7 lf_a held in valley cycle", int'(lf_a_o), 0);
      @(negedge clk);
      chk("R6 lf_a in negative half", int'(lf_a_o), 1);
      chk("R6 lf_b in negative half", int'(lf_b_o), 0);

      // R5: negative half, A main, B synchronous
      run_case("R5 negative half", 64, 20, 1'b0, 1'b1, 1'b1, 1'b1, 2, 2);

      // R8 / R9: trip the synchronous switch B mid-pulse, release at once
      do @(negedge clk); while (!hf_b_o);
      dcm_n_i = 1'b0;
      @(negedge clk);
      chk("R8 sync B off one cycle after flag low", int'(hf_b_o), 0);
      dcm_n_i = 1'b1;
      cnt = 0;
      while (!adc_soc_o) begin
         cnt += int'(hf_b_o);
         @(negedge clk);
      end
      chk("R9 sync B held off until valley", cnt, 0);
      cnt = 0;
      do begin
         cnt += int'(hf_b_o);
         @(negedge clk);
      end while (!adc_soc_o);
      chk("R9 sync B back after valley", cnt, 8);

      // R3: threshold arithmetic, no dead time, complementary widths
      run_case("R3 duty 200 top 32", 200, 32, 1'b1, 1'b1, 1'b1, 1'b1, 0, 2);
      // R10: longer dead time in negative half
      run_case("R10 dead time 5", 100, 25, 1'b0, 1'b1, 1'b1, 1'b1, 5, 2);
      // R8: flag held low, main keeps switching
      run_case("R8 flag held low", 64, 20, 1'b1, 1'b0, 1'b1, 1'b1, 2, 2);
      // R11: per-switch enables
      run_case("R11 B disabled", 64, 20, 1'b1, 1'b1, 1'b1, 1'b0, 2, 2);
      run_case("R11 A disabled", 64, 20, 1'b0, 1'b1, 1'b0, 1'b1, 2, 2);
      // R12: zero duty, main on for the full period
      run_case("R12 zero duty", 0, 16, 1'b1, 1'b1, 1'b1, 1'b1, 3, 2);
      // R10: near-full duty, main pulse narrower than dead time
      run_case("R10 main narrower than dead time", 255, 20, 1'b1, 1'b1, 1'b1, 1'b1, 3, 2);
      // R2: top below the floor and a large top
      run_case("R2 top below floor", 128, 1, 1'b0, 1'b1, 1'b1, 1'b1, 1, 3);
      run_case("R2 large top", 128, 500, 1'b1, 1'b1, 1'b1, 1'b1, 4, 2);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule